// File: doc/BRIEF.md
# Per-Connection Cell Statistics Counters

This block keeps two running cell counts for every connection of a receive path: one counts every user cell, the other counts only the user cells whose cell loss priority (CLP) bit is zero. Cells are offered on a valid/ready stream that carries a connection index and the CLP bit. Each accepted cell bumps the counters of its connection, provided counting is enabled for it. Whether counting is enabled is settled by two global controls and a per-connection enable bit. The global disable beats everything else, and the global enable beats the per-connection bit.

Both counters share one programmable wrap value. After reset the wrap value is all ones. A counter that holds the wrap value returns to zero on its next increment. If overflow reporting is switched on, that wrap produces an event on a second valid/ready stream. The event names the connection and the counter. Any counter can be read at any time through a combinational read port.

Back-pressure: `cell_ready` is high only while no overflow event is waiting. A cell is taken on a clock edge where `cell_valid` and `cell_ready` are both high. An event, once presented, holds its fields steady until the edge where `evt_ready` is high. A cell that is accepted while counting is disabled is consumed and changes nothing.

Top module: `cell_stat_counters`

## Requirements
- R1: After reset all counters read zero, `cell_ready` is 1, `evt_valid` is 0 and every per-connection enable is 0.
- R2: An accepted, enabled cell with CLP=0 adds one to both the total counter (`rd_sel`=0) and the CLP-0 counter (`rd_sel`=1) of its connection, and to no other connection's counters.
- R3: An accepted, enabled cell with CLP=1 adds one to the total counter only; the CLP-0 counter keeps its value.
- R4: While `glb_dis` is 1, accepted cells change no counter, whatever `glb_en` and the per-connection bits hold.
- R5: While `glb_en` is 1 and `glb_dis` is 0, every connection counts, even one whose own enable bit is 0.
- R6: With both global controls at 0, a connection counts only if its enable bit is 1. That bit is written through `en_we`/`en_idx`/`en_val`.
- R7: A counter that equals the wrap value becomes 0 on its next increment; below the wrap value it steps by one.
- R8: The wrap value resets to all ones and is replaced by `lim_wdata` on a clock edge with `lim_we` high.
- R9: A wrap raises an event only when `ovf_evt_en` is 1 at acceptance. The event carries `evt_conn` set to the connection and `evt_ctr` set to 0 for the total counter or 1 for the CLP-0 counter. It is presented from the cycle after acceptance.
- R10: When both counters wrap on one cell, two events follow each other: the total counter's event (`evt_ctr`=0) first, then the CLP-0 one (`evt_ctr`=1).
- R11: `cell_ready` is 0 while any event is pending. A presented event keeps `evt_conn` and `evt_ctr` stable until it is taken with `evt_ready`.
- R12: `rd_data` combinationally shows the counter picked by `rd_conn` and `rd_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cell_valid | input | 1 | A cell is offered |
| cell_ready | output | 1 | Cell can be taken (no event pending) |
| cell_conn | input | IDX_W | Connection index of the cell |
| cell_clp | input | 1 | Cell loss priority bit of the cell |
| glb_en | input | 1 | Global count enable |
| glb_dis | input | 1 | Global count disable, top priority |
| ovf_evt_en | input | 1 | Overflow event reporting enable |
| en_we | input | 1 | Write strobe for a per-connection enable |
| en_idx | input | IDX_W | Connection whose enable is written |
| en_val | input | 1 | New enable value |
| lim_we | input | 1 | Write strobe for the wrap value |
| lim_wdata | input | CNT_W | New wrap value |
| rd_conn | input | IDX_W | Connection to read |
| rd_sel | input | 1 | 0 total counter, 1 CLP-0 counter |
| rd_data | output | CNT_W | Selected counter value |
| evt_valid | output | 1 | Overflow event presented |
| evt_ready | input | 1 | Consumer takes the event |
| evt_conn | output | IDX_W | Connection of the event |
| evt_ctr | output | 1 | Counter of the event, 0 total, 1 CLP-0 |

## Verification
The checker takes for granted that the global controls, the overflow-report switch and the `evt_ready` line change only between clock edges, never in step with the sampling edge. It also assumes that a cell offered while `cell_ready` is low is simply not taken. The bench drives every input at the falling edge. It offers cells only after every pending event has been drained, and it holds `evt_ready` low for one cycle of each event before taking it. The random phase draws connections, CLP bits, the global controls and the enable bits with a fixed seed, against a wrap value small enough for wraps to occur often.

// File: rtl/cstat_pkg.sv
package cstat_pkg;
  typedef enum logic {
    CTR_ALL  = 1'b0,
    CTR_CLP0 = 1'b1
  } ctr_id_e;
endpackage

// File: rtl/cstat_gate.sv
// Per-connection enable bits plus the three-level decision for one connection.
module cstat_gate #(
  parameter int N_CONN = 16,
  parameter int IDX_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_we,
  input  logic [IDX_W-1:0] en_idx,
  input  logic             en_val,
  input  logic             glb_en,
  input  logic             glb_dis,
  input  logic [IDX_W-1:0] look_idx,
  output logic             cnt_en
);
  logic [N_CONN-1:0] en_q;
  logic              own_bit;

  for (genvar g = 0; g < N_CONN; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)
        en_q[g] <= 1'b0;
      else if (en_we && en_idx == IDX_W'(g))
        en_q[g] <= en_val;
    end
  end

  always_comb begin
    own_bit = 1'b0;
    for (int i = 0; i < N_CONN; i++)
      if (look_idx == IDX_W'(i)) own_bit = en_q[i];
  end

  // disable wins over enable, enable wins over the connection's own bit
  always_comb begin
    if (glb_dis)     cnt_en = 1'b0;
    else if (glb_en) cnt_en = 1'b1;
    else             cnt_en = own_bit;
  end
endmodule

// File: rtl/cstat_wrap_ctr.sv
// One counter that returns to zero after holding the wrap value.
module cstat_wrap_ctr #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bump,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] count,
  output logic             at_limit
);
  assign at_limit = (count == limit);

  always_ff @(posedge clk) begin
    if (!rst_n)
      count <= '0;
    else if (bump)
      count <= at_limit ? '0 : count + 1'b1;
  end
endmodule

// File: rtl/cstat_evq.sv
// Two-slot event holder: one cell can wrap at most two counters.
module cstat_evq #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_all,
  input  logic             push_c0,
  input  logic [IDX_W-1:0] push_conn,
  output logic             empty,
  output logic             evt_valid,
  input  logic             evt_ready,
  output logic [IDX_W-1:0] evt_conn,
  output logic             evt_ctr
);
  import cstat_pkg::*;

  logic             s0_v, s1_v;
  ctr_id_e          s0_id, s1_id;
  logic [IDX_W-1:0] s0_conn, s1_conn;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s0_v    <= 1'b0;
      s1_v    <= 1'b0;
      s0_id   <= CTR_ALL;
      s1_id   <= CTR_ALL;
      s0_conn <= '0;
      s1_conn <= '0;
    end else if (s0_v) begin
      if (evt_ready) begin
        s0_v    <= s1_v;
        s0_id   <= s1_id;
        s0_conn <= s1_conn;
        s1_v    <= 1'b0;
      end
    end else if (push_all || push_c0) begin
      s0_v    <= 1'b1;
      s0_id   <= push_all ? CTR_ALL : CTR_CLP0;
      s0_conn <= push_conn;
      s1_v    <= push_all && push_c0;
      s1_id   <= CTR_CLP0;
      s1_conn <= push_conn;
    end
  end

  assign empty     = !s0_v;
  assign evt_valid = s0_v;
  assign evt_conn  = s0_conn;
  assign evt_ctr   = logic'(s0_id);
endmodule

// File: rtl/cell_stat_counters.sv
module cell_stat_counters #(
  parameter int  N_CONN = 16,
  parameter int  CNT_W  = 32,
  localparam int IDX_W  = (N_CONN > 1) ? $clog2(N_CONN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cell_valid,
  output logic             cell_ready,
  input  logic [IDX_W-1:0] cell_conn,
  input  logic             cell_clp,
  input  logic             glb_en,
  input  logic             glb_dis,
  input  logic             ovf_evt_en,
  input  logic             en_we,
  input  logic [IDX_W-1:0] en_idx,
  input  logic             en_val,
  input  logic             lim_we,
  input  logic [CNT_W-1:0] lim_wdata,
  input  logic [IDX_W-1:0] rd_conn,
  input  logic             rd_sel,
  output logic [CNT_W-1:0] rd_data,
  output logic             evt_valid,
  input  logic             evt_ready,
  output logic [IDX_W-1:0] evt_conn,
  output logic             evt_ctr
);
  logic                          accept, cnt_en, bump;
  logic [CNT_W-1:0]              lim_q;
  logic [N_CONN-1:0][CNT_W-1:0]  tot_v, c0_v;
  logic [N_CONN-1:0]             tot_hit, c0_hit;
  logic                          hit_all, hit_c0;
  logic [CNT_W-1:0]              rd_tot, rd_c0;

  assign accept = cell_valid && cell_ready;
  assign bump   = accept && cnt_en;

  always_ff @(posedge clk) begin
    if (!rst_n)      lim_q <= '1;
    else if (lim_we) lim_q <= lim_wdata;
  end

  cstat_gate #(.N_CONN(N_CONN), .IDX_W(IDX_W)) u_gate (
    .clk(clk), .rst_n(rst_n),
    .en_we(en_we), .en_idx(en_idx), .en_val(en_val),
    .glb_en(glb_en), .glb_dis(glb_dis),
    .look_idx(cell_conn), .cnt_en(cnt_en)
  );

  for (genvar g = 0; g < N_CONN; g++) begin : g_conn
    logic here;
    assign here = (cell_conn == IDX_W'(g));

    cstat_wrap_ctr #(.CNT_W(CNT_W)) u_tot (
      .clk(clk), .rst_n(rst_n),
      .bump(bump && here), .limit(lim_q),
      .count(tot_v[g]), .at_limit(tot_hit[g])
    );

    cstat_wrap_ctr #(.CNT_W(CNT_W)) u_c0 (
      .clk(clk), .rst_n(rst_n),
      .bump(bump && here && !cell_clp), .limit(lim_q),
      .count(c0_v[g]), .at_limit(c0_hit[g])
    );
  end

  // wrap detection and read selection for the addressed connection
  always_comb begin
    hit_all = 1'b0;
    hit_c0  = 1'b0;
    rd_tot  = '0;
    rd_c0   = '0;
    for (int i = 0; i < N_CONN; i++) begin
      if (cell_conn == IDX_W'(i)) begin
        hit_all = tot_hit[i];
        hit_c0  = c0_hit[i];
      end
      if (rd_conn == IDX_W'(i)) begin
        rd_tot = tot_v[i];
        rd_c0  = c0_v[i];
      end
    end
  end

  assign rd_data = rd_sel ? rd_c0 : rd_tot;

  cstat_evq #(.IDX_W(IDX_W)) u_evq (
    .clk(clk), .rst_n(rst_n),
    .push_all(bump && ovf_evt_en && hit_all),
    .push_c0(bump && ovf_evt_en && hit_c0 && !cell_clp),
    .push_conn(cell_conn),
    .empty(cell_ready),
    .evt_valid(evt_valid), .evt_ready(evt_ready),
    .evt_conn(evt_conn), .evt_ctr(evt_ctr)
  );
endmodule

// File: rtl/cell_stat_counters_chk.sv
module cell_stat_counters_chk #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cell_valid,
  input logic             cell_ready,
  input logic             glb_en,
  input logic             glb_dis,
  input logic             cnt_en,
  input logic             ovf_evt_en,
  input logic             evt_valid,
  input logic             evt_ready,
  input logic [IDX_W-1:0] evt_conn,
  input logic             evt_ctr
);
  // R11: nothing is accepted while an event waits
  a_r11_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> !cell_ready);

  // R11: a presented event keeps its fields until taken
  a_r11_evt_stable: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && !evt_ready |=> evt_valid && $stable(evt_conn) && $stable(evt_ctr));

  // R9: reporting switched off means no event follows an accepted cell
  a_r9_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    cell_valid && cell_ready && !ovf_evt_en |=> !evt_valid);

  // R4: global disable blocks counting
  a_r4_global_off: assert property (@(posedge clk) disable iff (!rst_n)
    glb_dis |-> !cnt_en);

  // R5: global enable forces counting when not disabled
  a_r5_global_on: assert property (@(posedge clk) disable iff (!rst_n)
    glb_en && !glb_dis |-> cnt_en);

  // R10: the CLP-0 event is always the last of a cell's events
  a_r10_clp0_last: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && evt_ready && evt_ctr |=> !evt_valid);
endmodule

bind cell_stat_counters cell_stat_counters_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .cell_valid(cell_valid), .cell_ready(cell_ready),
  .glb_en(glb_en), .glb_dis(glb_dis), .cnt_en(cnt_en),
  .ovf_evt_en(ovf_evt_en),
  .evt_valid(evt_valid), .evt_ready(evt_ready),
  .evt_conn(evt_conn), .evt_ctr(evt_ctr)
);

// File: tb/cell_stat_counters_test.sv
module cell_stat_counters_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;
  localparam int W = 32;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cell_valid = 1'b0, cell_clp = 1'b0;
  logic [IW-1:0] cell_conn = '0;
  logic cell_ready;
  logic glb_en = 1'b0, glb_dis = 1'b0, ovf_evt_en = 1'b0;
  logic en_we = 1'b0, en_val = 1'b0;
  logic [IW-1:0] en_idx = '0;
  logic lim_we = 1'b0;
  logic [W-1:0] lim_wdata = '0;
  logic [IW-1:0] rd_conn = '0;
  logic rd_sel = 1'b0;
  logic [W-1:0] rd_data;
  logic evt_valid, evt_ctr;
  logic evt_ready = 1'b0;
  logic [IW-1:0] evt_conn;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [W-1:0] m_tot [N];
  logic [W-1:0] m_c0 [N];
  bit           m_en [N];
  logic [W-1:0] m_lim;

  always #(CLK_PERIOD/2) clk = ~clk;

  cell_stat_counters #(.N_CONN(N), .CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n),
    .cell_valid(cell_valid), .cell_ready(cell_ready),
    .cell_conn(cell_conn), .cell_clp(cell_clp),
    .glb_en(glb_en), .glb_dis(glb_dis), .ovf_evt_en(ovf_evt_en),
    .en_we(en_we), .en_idx(en_idx), .en_val(en_val),
    .lim_we(lim_we), .lim_wdata(lim_wdata),
    .rd_conn(rd_conn), .rd_sel(rd_sel), .rd_data(rd_data),
    .evt_valid(evt_valid), .evt_ready(evt_ready),
    .evt_conn(evt_conn), .evt_ctr(evt_ctr)
  );

  function automatic logic [W-1:0] step(input logic [W-1:0] c, input logic [W-1:0] l);
    return (c == l) ? '0 : c + 1'b1;
  endfunction

  function automatic bit counts(input int conn);
    if (glb_dis) return 1'b0;
    if (glb_en) return 1'b1;
    return m_en[conn];
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic read_conn(input int conn, input string req);
    rd_conn = IW'(conn);
    rd_sel = 1'b0;
    #1 check({req, " R12 total"}, rd_data, m_tot[conn]);
    rd_sel = 1'b1;
    #1 check({req, " R12 clp0"}, rd_data, m_c0[conn]);
  endtask

  task automatic wr_en(input int conn, input bit val);
    en_we = 1'b1; en_idx = IW'(conn); en_val = val;
    @(negedge clk);
    en_we = 1'b0;
    m_en[conn] = val;
  endtask

  task automatic wr_lim(input logic [W-1:0] v);
    lim_we = 1'b1; lim_wdata = v;
    @(negedge clk);
    lim_we = 1'b0;
    m_lim = v;
  endtask

  // offer one cell at a falling edge; expects no pending event beforehand
  task automatic send_cell(input int conn, input bit clp, input string req);
    int nexp = 0;
    int ids [2];
    if (counts(conn)) begin
      if (m_tot[conn] == m_lim && ovf_evt_en) begin ids[nexp] = 0; nexp++; end
      m_tot[conn] = step(m_tot[conn], m_lim);
      if (!clp) begin
        if (m_c0[conn] == m_lim && ovf_evt_en) begin ids[nexp] = 1; nexp++; end
        m_c0[conn] = step(m_c0[conn], m_lim);
      end
    end
    cell_valid = 1'b1; cell_conn = IW'(conn); cell_clp = clp;
    @(negedge clk);
    cell_valid = 1'b0;
    check({req, " R11 ready"}, W'(cell_ready), W'(nexp == 0));
    for (int k = 0; k < nexp; k++) begin
      check({req, " R9 valid"}, W'(evt_valid), 1);
      check({req, " R9 conn"}, W'(evt_conn), W'(conn));
      check({req, " R10 ctr"}, W'(evt_ctr), W'(ids[k]));
      @(negedge clk);
      check({req, " R11 held"}, W'(evt_valid), 1);
      check({req, " R11 held ctr"}, W'(evt_ctr), W'(ids[k]));
      evt_ready = 1'b1;
      @(negedge clk);
      evt_ready = 1'b0;
    end
    check({req, " R9 drained"}, W'(evt_valid), 0);
    read_conn(conn, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < N; i++) begin m_tot[i] = '0; m_c0[i] = '0; m_en[i] = 0; end
    m_lim = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1 ready", W'(cell_ready), 1);
    check("R1 evt", W'(evt_valid), 0);
    for (int i = 0; i < N; i++) read_conn(i, "R1");

    // R1/R6: enables reset to 0, so nothing counts with globals low
    send_cell(2, 0, "R1 enable reset");

    // R8: default wrap is all ones, so 20 cells give no event
    glb_en = 1'b1; ovf_evt_en = 1'b1;
    for (int i = 0; i < 20; i++) send_cell(3, i[0], "R8 default wrap");
    // R2/R3 sanity on counts and neighbours
    check("R3 total", m_tot[3], 20);
    check("R3 clp0", m_c0[3], 10);
    read_conn(4, "R2 neighbour");

    // R4: global disable wins
    glb_dis = 1'b1;
    send_cell(3, 0, "R4 disable");
    send_cell(5, 0, "R4 disable");
    glb_dis = 1'b0;

    // R6: per-connection bit decides with globals low
    glb_en = 1'b0;
    wr_en(5, 1);
    send_cell(5, 0, "R6 own on");
    send_cell(6, 0, "R6 own off");
    // R5: global enable overrides a cleared bit
    glb_en = 1'b1;
    send_cell(6, 1, "R5 global on");

    // R7/R9/R10: small wrap value
    wr_lim(32'd4);
    for (int i = 0; i < 5; i++) send_cell(7, 0, "R10 both wrap");
    check("R7 wrapped total", m_tot[7], 0);
    // R3/R9: CLP=1 wraps only the total counter
    for (int i = 0; i < 4; i++) send_cell(8, 0, "R7 fill");
    send_cell(8, 1, "R9 total only");
    check("R3 clp0 kept", m_c0[8], 4);
    // R9: reporting off, wrap silent
    ovf_evt_en = 1'b0;
    for (int i = 0; i < 5; i++) send_cell(9, 0, "R9 quiet");

    // random phase
    wr_lim(32'd6);
    for (int i = 0; i < 400; i++) begin
      int c;
      c = int'($urandom_range(N-1, 0));
      if ($urandom_range(9, 0) == 0) glb_dis = 1'($urandom_range(1, 0));
      if ($urandom_range(9, 0) == 0) glb_en = 1'($urandom_range(1, 0));
      if ($urandom_range(7, 0) == 0) ovf_evt_en = 1'($urandom_range(1, 0));
      if ($urandom_range(7, 0) == 0) wr_en(int'($urandom_range(N-1, 0)), 1'($urandom_range(1, 0)));
      send_cell(c, 1'($urandom_range(1, 0)), "R2 random");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule